// File: doc/BRIEF.md
# Signed Saturating SIMD Add/Subtract Unit

A purely combinational arithmetic unit for a 32-bit processor datapath. It takes two 32-bit operands, a 4-bit operation code and the current status word. It returns a 32-bit result and an updated status word. Every operation clamps its results to the signed range of its lane instead of wrapping.

The operations come in three groups. The first is full-width add and subtract, with doubling variants in which the second operand is first saturated-doubled. The second is packed 2×16-bit and 4×8-bit add and subtract. The third is two cross forms that pair each half of the first operand with the opposite half of the second.

Only the full-width forms touch the status word. They can set a single sticky saturation bit and never clear it. Decode, register access and pipelining belong to the surrounding datapath.

Top module: `sat_simd_unit`

## Requirements
- R1: Each lane sign-extends both operands by one bit and forms the exact sum or difference. Subtraction is computed as a + ~b + 1 at width+1 bits. The lane has saturated when the two top bits of this extended result differ.
- R2: A saturated lane outputs 2^(w-1)-1 when the exact result is positive and -2^(w-1) when it is negative. An unsaturated lane outputs the low w bits of the exact result.
- R3: The full-width forms are code 0 (op1+op2) and code 1 (op1-op2). Each saturates at 32 bits. Status bit 27 is ORed with the saturation indication.
- R4: Code 2 and code 3 first saturate op2+op2 to 32 bits. Code 2 then computes the saturating sum op1 + that value, and code 3 computes op1 minus that value. Status bit 27 is set when either step saturates.
- R5: Code 4 adds and code 5 subtracts two independent 16-bit lanes. Lane i occupies bits [16i+15:16i].
- R6: Code 6 adds and code 7 subtracts four independent 8-bit lanes. Lane i occupies bits [8i+7:8i].
- R7: Code 8 puts op1[15:0]-op2[31:16] in result[15:0] and op1[31:16]+op2[15:0] in result[31:16]. Each half saturates at 16 bits.
- R8: Code 9 puts op1[15:0]+op2[31:16] in result[15:0] and op1[31:16]-op2[15:0] in result[31:16]. Each half saturates at 16 bits.
- R9: Codes 4 to 9 return the status word unchanged. Every operation leaves all status bits except bit 27 unchanged. Bit 27 is never cleared.
- R10: Codes 10 to 15 return op1 as the result and the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op1_i | input | 32 | First operand |
| op2_i | input | 32 | Second operand |
| op_sel_i | input | 4 | Operation code (0 to 9 defined) |
| status_i | input | 32 | Current status word |
| result_o | output | 32 | Saturated result |
| status_o | output | 32 | Updated status word |

## Verification
Every operation code is driven with every pairing of sixteen corner operands, across both states of the incoming sticky bit.

The corners include each lane's maximum and minimum, ±1 and half-scale values, and mixed per-lane patterns. These separate a clamp to the wrong rail or a missing clamp, a lane that borrows from its neighbour, a swapped half in the cross forms, and a doubling step that skips its own saturation.

Directed vectors 0x7FFFFFFF+1, 0x80000000-1 and the doubling of 0x40000000 target the rail crossings. A pseudo-random stream follows to cover ordinary in-range arithmetic.

// File: rtl/sat_simd_pkg.sv
// Package: shared operation codes for the saturating SIMD unit.
// Assumes a 4-bit operation select; codes above OP_SAX are pass-through.
package sat_simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD32  = 4'd0,
        OP_SUB32  = 4'd1,
        OP_DADD32 = 4'd2,
        OP_DSUB32 = 4'd3,
        OP_ADD16  = 4'd4,
        OP_SUB16  = 4'd5,
        OP_ADD8   = 4'd6,
        OP_SUB8   = 4'd7,
        OP_ASX    = 4'd8,
        OP_SAX    = 4'd9
    } sat_op_e;

endpackage

// File: rtl/sat_lane.sv
// Module: one signed saturating adder/subtractor lane of width W.
// Assumes two's-complement operands; purely combinational.
module sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] sum_ext;

    // Sign-extend and form the exact result at W+1 bits (subtract as a + ~b + 1).
    always_comb begin
        a_ext   = {a_i[W-1], a_i};
        b_ext   = {b_i[W-1], b_i};
        sum_ext = a_ext + (sub_i ? ~b_ext : b_ext) + {{W{1'b0}}, sub_i};
    end

    // Detect overflow and clamp toward the rail matching the exact sign.
    always_comb begin
        sat_o = sum_ext[W] ^ sum_ext[W-1];
        if (sat_o) res_o = sum_ext[W] ? MIN_V : MAX_V;
        else       res_o = sum_ext[W-1:0];
    end

    // Guards on the lane arithmetic.
    always_comb begin
        // R2: a saturated lane sits on one of the two rails.
        a_r2_clamp_rail: assert (!sat_o || res_o == MAX_V || res_o == MIN_V);
        // R1: an add can only overflow when both operands share a sign.
        a_r1_add_sign: assert (!(sat_o && !sub_i) || (a_i[W-1] == b_i[W-1]));
        // R1: a subtract can only overflow when the operand signs differ.
        a_r1_sub_sign: assert (!(sat_o && sub_i) || (a_i[W-1] != b_i[W-1]));
    end

endmodule

// File: rtl/sat_packed.sv
// Module: N independent saturating lanes of width W packed in one word.
// Assumes lane i occupies bits [(i+1)*W-1 : i*W]; per-lane add/sub select.
module sat_packed #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N*W-1:0] a_i,
    input  logic [N*W-1:0] b_i,
    input  logic [N-1:0]   sub_i,
    output logic [N*W-1:0] res_o,
    output logic [N-1:0]   sat_o
);
    // One lane per slice of the packed word.
    for (genvar g = 0; g < N; g++) begin : g_lane
        sat_lane #(.W(W)) u_lane (
            .a_i   (a_i[g*W +: W]),
            .b_i   (b_i[g*W +: W]),
            .sub_i (sub_i[g]),
            .res_o (res_o[g*W +: W]),
            .sat_o (sat_o[g])
        );
    end

endmodule

// File: rtl/sat_simd_unit.sv
// Module: top of the signed saturating SIMD add/subtract unit.
// Assumes a combinational datapath slot; only full-width forms may set the
// sticky bit at STICKY_POS, and no other status bit is ever written.
module sat_simd_unit
    import sat_simd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int STICKY_POS = 27
) (
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] op2_i,
    input  logic [3:0]        op_sel_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] status_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;

    sat_op_e op;
    logic    is_dbl;
    logic    main_sub;
    logic    wide_op;

    logic [DATA_W-1:0] dbl_res;
    logic              dbl_sat;
    logic [DATA_W-1:0] main_b;
    logic [DATA_W-1:0] main_res;
    logic              main_sat;

    logic [DATA_W-1:0] h_b;
    logic [1:0]        h_sub;
    logic [DATA_W-1:0] h_res;
    logic [1:0]        h_sat;

    logic [3:0]        q_sub;
    logic [DATA_W-1:0] q_res;
    logic [3:0]        q_sat;

    logic              sticky_set;

    // Decode the operation select into datapath controls.
    always_comb begin
        op       = sat_op_e'(op_sel_i);
        is_dbl   = (op == OP_DADD32) || (op == OP_DSUB32);
        main_sub = (op == OP_SUB32) || (op == OP_DSUB32);
        wide_op  = (op == OP_ADD32) || (op == OP_SUB32) || is_dbl;
    end

    // Doubling stage: saturated op2 + op2.
    sat_lane #(.W(DATA_W)) u_dbl (
        .a_i   (op2_i),
        .b_i   (op2_i),
        .sub_i (1'b0),
        .res_o (dbl_res),
        .sat_o (dbl_sat)
    );

    // Select the second full-width operand: raw or doubled.
    always_comb main_b = is_dbl ? dbl_res : op2_i;

    // Full-width saturating add/subtract stage.
    sat_lane #(.W(DATA_W)) u_main (
        .a_i   (op1_i),
        .b_i   (main_b),
        .sub_i (main_sub),
        .res_o (main_res),
        .sat_o (main_sat)
    );

    // Half-word lane controls: exchange forms swap op2 halves.
    always_comb begin
        h_b   = op2_i;
        h_sub = 2'b00;
        unique case (op)
            OP_SUB16: h_sub = 2'b11;
            OP_ASX: begin
                h_b   = {op2_i[HALF_W-1:0], op2_i[DATA_W-1:HALF_W]};
                h_sub = 2'b01;
            end
            OP_SAX: begin
                h_b   = {op2_i[HALF_W-1:0], op2_i[DATA_W-1:HALF_W]};
                h_sub = 2'b10;
            end
            default: h_sub = 2'b00;
        endcase
    end

    sat_packed #(.W(HALF_W), .N(2)) u_half (
        .a_i   (op1_i),
        .b_i   (h_b),
        .sub_i (h_sub),
        .res_o (h_res),
        .sat_o (h_sat)
    );

    // Byte lane controls: all lanes share one direction.
    always_comb q_sub = (op == OP_SUB8) ? 4'b1111 : 4'b0000;

    sat_packed #(.W(QTR_W), .N(4)) u_quarter (
        .a_i   (op1_i),
        .b_i   (op2_i),
        .sub_i (q_sub),
        .res_o (q_res),
        .sat_o (q_sat)
    );

    // Route the selected datapath to the result port.
    always_comb begin
        unique case (op)
            OP_ADD32, OP_SUB32, OP_DADD32, OP_DSUB32: result_o = main_res;
            OP_ADD16, OP_SUB16, OP_ASX, OP_SAX:       result_o = h_res;
            OP_ADD8, OP_SUB8:                         result_o = q_res;
            default:                                  result_o = op1_i;
        endcase
    end

    // Sticky update: OR in saturation from full-width forms only.
    always_comb begin
        sticky_set = wide_op && (main_sat || (is_dbl && dbl_sat));
        status_o   = status_i;
        status_o[STICKY_POS] = status_i[STICKY_POS] | sticky_set;
    end

    // Guards on the status word behaviour.
    always_comb begin
        // R9: bits other than the sticky bit never change.
        a_r9_other_bits_kept: assert ((status_o ^ status_i) ==
                                      ((status_o ^ status_i) & (DATA_W'(1) << STICKY_POS)));
        // R9: the sticky bit is never cleared.
        a_r9_sticky_no_clear: assert (!status_i[STICKY_POS] || status_o[STICKY_POS]);
        // R9: packed saturation leaves the status word untouched.
        a_r9_packed_quiet: assert (wide_op || !(|h_sat || |q_sat) || status_o == status_i);
        // R3: full-width saturation always leaves the sticky bit set.
        a_r3_sticky_on_sat: assert (!(wide_op && main_sat) || status_o[STICKY_POS]);
        // R10: unused codes pass op1 through.
        a_r10_passthru: assert (op_sel_i <= 4'd9 || (result_o == op1_i && status_o == status_i));
    end

endmodule

// File: tb/sat_simd_unit_bench.sv
// Bench: sweeps every op code over corner operand pairs plus a pseudo-random
// stream, comparing against exact integer arithmetic.
module sat_simd_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op1, op2, st_in;
    logic [3:0]  sel;
    logic [31:0] res, st_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_simd_unit u_sat_simd_unit (
        .op1_i    (op1),
        .op2_i    (op2),
        .op_sel_i (sel),
        .status_i (st_in),
        .result_o (res),
        .status_o (st_out)
    );

    function automatic longint sx(logic [31:0] v, int w);
        longint m = (64'sd1 <<< w) - 1;
        longint x = longint'(v) & m;
        if (x >= (64'sd1 <<< (w-1))) x = x - (64'sd1 <<< w);
        return x;
    endfunction

    function automatic longint rsat(longint a, longint b, bit sub, int w, output bit s);
        longint r  = sub ? a - b : a + b;
        longint mx = (64'sd1 <<< (w-1)) - 1;
        longint mn = -(64'sd1 <<< (w-1));
        s = 1'b0;
        if (r > mx) begin s = 1'b1; r = mx; end
        else if (r < mn) begin s = 1'b1; r = mn; end
        return r;
    endfunction

    function automatic logic [31:0] corner(int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'hFFFF_FFFF;
            3:  return 32'h7FFF_FFFF;
            4:  return 32'h8000_0000;
            5:  return 32'h4000_0000;
            6:  return 32'hC000_0000;
            7:  return 32'h3FFF_FFFF;
            8:  return 32'h7FFF_8000;
            9:  return 32'h8000_7FFF;
            10: return 32'h7F7F_7F7F;
            11: return 32'h8080_8080;
            12: return 32'h017F_80FF;
            13: return 32'hFF01_807F;
            14: return 32'h0001_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    // Compute expected result and status for one vector.
    task automatic model(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] st, output logic [31:0] er,
                         output logic [31:0] es, output string req);
        bit f1, f2;
        longint r, d;
        er = a; es = st; f1 = 0; f2 = 0;
        case (s)
            4'd0, 4'd1: begin
                r = rsat(sx(a,32), sx(b,32), s[0], 32, f1);
                er = r[31:0]; es[27] = st[27] | f1; req = "R3";
            end
            4'd2, 4'd3: begin
                d = rsat(sx(b,32), sx(b,32), 1'b0, 32, f1);
                r = rsat(sx(a,32), d, s[0], 32, f2);
                er = r[31:0]; es[27] = st[27] | f1 | f2; req = "R4";
            end
            4'd4, 4'd5: begin
                for (int i = 0; i < 2; i++) begin
                    r = rsat(sx(a >> (16*i),16), sx(b >> (16*i),16), s[0], 16, f1);
                    er[16*i +: 16] = r[15:0];
                end
                req = "R5";
            end
            4'd6, 4'd7: begin
                for (int i = 0; i < 4; i++) begin
                    r = rsat(sx(a >> (8*i),8), sx(b >> (8*i),8), s[0], 8, f1);
                    er[8*i +: 8] = r[7:0];
                end
                req = "R6";
            end
            4'd8: begin
                r = rsat(sx(a,16), sx(b >> 16,16), 1'b1, 16, f1); er[15:0] = r[15:0];
                r = rsat(sx(a >> 16,16), sx(b,16), 1'b0, 16, f1); er[31:16] = r[15:0];
                req = "R7";
            end
            4'd9: begin
                r = rsat(sx(a,16), sx(b >> 16,16), 1'b0, 16, f1); er[15:0] = r[15:0];
                r = rsat(sx(a >> 16,16), sx(b,16), 1'b1, 16, f1); er[31:16] = r[15:0];
                req = "R8";
            end
            default: req = "R10";
        endcase
    endtask

    // Apply one vector, wait, compare result and status (R1, R2, R9 throughout).
    task automatic apply(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] st);
        logic [31:0] er, es;
        string req;
        @(negedge clk);
        sel = s; op1 = a; op2 = b; st_in = st;
        model(s, a, b, st, er, es, req);
        #1;
        checks++;
        if (res !== er || st_out !== es) begin
            failures++;
            $display("FAIL %s/R1/R2/R9 op=%0d a=%h b=%h: result=%h status=%h expected result=%h status=%h",
                     req, s, a, b, res, st_out, er, es);
        end
    endtask

    initial begin
        int cnt = 0;
        while (!done) begin
            @(posedge clk);
            cnt++;
            if (cnt > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] lfsr;
        sel = 4'd0; op1 = 0; op2 = 0; st_in = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state: zero inputs give zero outputs (R3).
        #1; checks++;
        if (res !== 0 || st_out !== 0) begin
            failures++;
            $display("FAIL R3 idle: result=%h status=%h expected 0/0", res, st_out);
        end
        // Directed rail crossings (R3, R4, R2).
        apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000);
        apply(4'd1, 32'h8000_0000, 32'h0000_0001, 32'hF000_0000);
        apply(4'd2, 32'h0000_0000, 32'h4000_0000, 32'h0000_0000);
        apply(4'd3, 32'h0000_0000, 32'h4000_0000, 32'h0800_0000);
        apply(4'd2, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000);
        // Unused codes (R10).
        for (int s = 10; s < 16; s++) apply(4'(s), 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h0000_0003);
        // Corner sweep across all codes and both sticky states.
        for (int s = 0; s < 10; s++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(4'(s), corner(i), corner(j), ((i + j) % 2 == 1) ? 32'h0800_00A5 : 32'hF000_0000);
        // Pseudo-random in-range stream.
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; a = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            apply(4'(k % 16), a, lfsr, {a[7:0], lfsr[31:8]});
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule